// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register with Daisy-Chain Output

This block is the digital input stage of a serial-input digital-to-analog converter. A host sends a code word over three wires: a serial clock, a data line, and one select line that both enables the serial clock and commits the word. While the select line is low, each rising serial clock edge moves one data bit into a shift register, most significant bit first. When the select line rises, the contents of the shift register are copied into a holding register. The holding register drives the parallel code that goes to the converter.

The bit that leaves the far end of the shift register is driven on a serial output. Several devices can therefore be chained, with the serial output of one feeding the data input of the next. All three serial inputs are sampled into one system-clock domain through two-flop synchronizers. Edges are detected after synchronization. A synchronous power-on reset and an active-low clear input each zero both registers. The clear takes effect asynchronously and is released in step with the system clock.

Top module: `serial_dac_loader`

## Requirements
- R1: With `rst_n` low at a rising `clk` edge, both the shift register and the holding register become zero, so `dac_code` = 0 and `sdo` = 0.
- R2: While `csld` is low, each rising `sclk` edge shifts `sdi` into bit 0 and moves every bit up one position. The first bit sent therefore ends up in bit 11, the MSB.
- R3: While `csld` is high, `sclk` edges are ignored and the shift register keeps its contents. This is seen on `sdo` and in the word that a later load commits.
- R4: `dac_code` changes only on a rising `csld` or on a clear.
- R5: A rising `csld` copies the shift register into the holding register, and the copy appears on `dac_code`.
- R6: `sdo` always equals bit 11 of the shift register and changes only on an accepted serial clock edge. After a load, the next 12 clocks therefore present the previous word on `sdo`, MSB first.
- R7: If a frame contains more or fewer than 12 clocks, the word loaded is the last 12 bits shifted in, with bits left over from earlier frames filling the upper positions. A miscount is not flagged.
- R8: A low level on `clr_n` forces both registers to zero at once, without waiting for a `clk` edge.
- R9: Until the release of `clr_n` has passed through two `clk` flops, shifts and loads are ignored. A load that coincides with a clear leaves `dac_code` at zero.
- R10: If a rising `sclk` and a rising `csld` reach the synchronizer outputs in the same cycle, the clock edge is ignored and the load commits the word as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| clr_n | input | 1 | Active-low clear of both registers; asserts asynchronously, releases synchronously |
| sclk | input | 1 | Serial clock (asynchronous to `clk`) |
| sdi | input | 1 | Serial data in, MSB first |
| csld | input | 1 | Low: enables the serial clock; rising edge: loads the DAC code |
| sdo | output | 1 | Serial data out, the MSB of the shift register, for daisy-chaining |
| dac_code | output | 12 | Parallel code held for the converter |

## Verification
Two pairs of events can land in the same cycle. The first is a load request with a clear. The bench raises `csld` while `clr_n` is held low, releases the clear, and then expects `dac_code` to read zero. The second is a final serial clock edge with a load. The bench raises `sclk` and `csld` on the same `clk` edge, so both rises leave the synchronizers together. It then expects the committed word and `sdo` to show the shift register as it was before that clock edge.

// File: rtl/sdl_pkg.sv
// Package: shared defaults and the strobe type for the serial DAC loader.
// Assumes the word width is at least 2 and the synchronizer depth is at least 2.
package sdl_pkg;
    localparam int unsigned WORD_W_DEF = 12;
    localparam int unsigned SYNC_DEF   = 2;

    // One-cycle strobes decoded from the synchronized serial inputs.
    typedef struct packed {
        logic shift;
        logic load;
    } sdl_strobe_t;
endpackage

// File: rtl/sdl_sync.sv
// Module: multi-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a level that stays stable much longer than one clk period.
// Synchronous active-low reset loads RST_VAL into every stage.
module sdl_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    stage_q[g] <= d;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sdl_strobe.sv
// Module: turns the synchronized serial clock and select levels into strobes.
// Shift fires on a rising serial clock while select is low. Load fires on a
// rising select. Reset values treat the select line as idle high and the serial
// clock as idle low, so no strobe fires when reset is released.
module sdl_strobe (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_s,
    input  logic                csld_s,
    output sdl_pkg::sdl_strobe_t strobe
);
    logic sclk_prev;
    logic csld_prev;

    // Purpose: remember last cycle's synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            csld_prev <= 1'b1;
        end else begin
            sclk_prev <= sclk_s;
            csld_prev <= csld_s;
        end
    end

    // Purpose: decode edges; select high blocks the serial clock.
    always_comb begin
        strobe.shift = sclk_s & ~sclk_prev & ~csld_s;
        strobe.load  = csld_s & ~csld_prev;
    end
endmodule

// File: rtl/sdl_regs.sv
// Module: shift register and holding register for the DAC code.
// clr_n zeroes both registers asynchronously. While clr_rel is low (the clear
// release has not yet been synchronized) they stay at zero and ignore strobes.
// rst_n is the synchronous power-on reset.
module sdl_regs #(
    parameter int unsigned WORD_W = sdl_pkg::WORD_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_n,
    input  logic                 clr_rel,
    input  logic                 sdi_s,
    input  sdl_pkg::sdl_strobe_t strobe,
    output logic [WORD_W-1:0]    shift_q,
    output logic [WORD_W-1:0]    dac_q
);
    // Purpose: MSB-first shift register fed at bit 0.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            shift_q <= '0;
        end else if (!rst_n || !clr_rel) begin
            shift_q <= '0;
        end else if (strobe.shift) begin
            shift_q <= {shift_q[WORD_W-2:0], sdi_s};
        end
    end

    // Purpose: holding register updated by the load strobe.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            dac_q <= '0;
        end else if (!rst_n || !clr_rel) begin
            dac_q <= '0;
        end else if (strobe.load) begin
            dac_q <= shift_q;
        end
    end
endmodule

// File: rtl/serial_dac_loader.sv
// Module: top of the serial DAC loader.
// Synchronizes sclk, sdi and csld into clk, decodes shift and load strobes,
// and holds the shift and DAC registers. sdo is the MSB of the shift register.
// Assumes the serial inputs are held for several clk periods per phase and that
// sdi is settled before the matching sclk rise.
module serial_dac_loader #(
    parameter int unsigned WORD_W = sdl_pkg::WORD_W_DEF,
    parameter int unsigned SYNC_N = sdl_pkg::SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              csld,
    output logic              sdo,
    output logic [WORD_W-1:0] dac_code
);
    localparam int unsigned IN_W = 3;

    logic [IN_W-1:0]      in_s;
    logic [SYNC_N-1:0]    rel_pipe;
    logic                 clr_rel;
    sdl_pkg::sdl_strobe_t strobe;
    logic [WORD_W-1:0]    shift_word;
    logic [WORD_W-1:0]    dac_word;

    // The three serial inputs share one synchronizer; csld resets high (idle).
    sdl_sync #(
        .WIDTH   (IN_W),
        .STAGES  (SYNC_N),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({csld, sclk, sdi}),
        .q     (in_s)
    );

    // Purpose: clear asserts at once and releases after SYNC_N clk edges.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            rel_pipe <= '0;
        end else if (!rst_n) begin
            rel_pipe <= '0;
        end else begin
            rel_pipe <= {rel_pipe[SYNC_N-2:0], 1'b1};
        end
    end
    assign clr_rel = rel_pipe[SYNC_N-1];

    sdl_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (in_s[1]),
        .csld_s (in_s[2]),
        .strobe (strobe)
    );

    sdl_regs #(
        .WORD_W (WORD_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .clr_rel (clr_rel),
        .sdi_s   (in_s[0]),
        .strobe  (strobe),
        .shift_q (shift_word),
        .dac_q   (dac_word)
    );

    assign sdo      = shift_word[WORD_W-1];
    assign dac_code = dac_word;
endmodule

// File: rtl/sdl_checker.sv
// Module: assertion checker bound into serial_dac_loader.
// Observes the strobes and both registers; it drives nothing.
module sdl_checker #(
    parameter int unsigned WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              clr_rel,
    input logic              shift_stb,
    input logic              load_stb,
    input logic [WORD_W-1:0] shift_q,
    input logic [WORD_W-1:0] dac_q
);
    // R1: power-on reset zeroes both registers.
    assert_por_zero_R1: assert property (@(posedge clk) disable iff (!clr_n)
        !rst_n |=> (shift_q == '0 && dac_q == '0));

    // R2: an accepted shift moves every bit up one place.
    assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (shift_stb && clr_rel) |=> shift_q[WORD_W-1:1] == $past(shift_q[WORD_W-2:0]));

    // R3: without a shift strobe, the shift register holds.
    assert_shift_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!shift_stb && clr_rel) |=> $stable(shift_q));

    // R4: without a load strobe, the DAC code holds.
    assert_dac_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !load_stb |=> $stable(dac_q));

    // R5: a load copies the shift register.
    assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (load_stb && clr_rel) |=> dac_q == $past(shift_q));

    // R8: while clear is low, both registers read zero.
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (shift_q == '0 && dac_q == '0));

    // R9: before the release is synchronized, loads are ignored.
    assert_clear_blocks_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_rel |=> dac_q == '0);
endmodule

bind serial_dac_loader sdl_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .clr_rel   (clr_rel),
    .shift_stb (strobe.shift),
    .load_stb  (strobe.load),
    .shift_q   (shift_word),
    .dac_q     (dac_word)
);

// File: tb/serial_dac_loader_tb.sv
// Bench: directed corner cases plus seeded random frames, checked against a
// bench-side model of the shift and holding registers.
module serial_dac_loader_tb;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic         csld = 1'b1;
    logic         sdo;
    logic [W-1:0] dac_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] m_shift = '0;
    logic [W-1:0] m_dac = '0;

    always #10 clk = ~clk;

    serial_dac_loader u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .csld     (csld),
        .sdo      (sdo),
        .dac_code (dac_code)
    );

    function automatic logic [W-1:0] shift_in(logic [W-1:0] cur, logic b);
        return {cur[W-2:0], b};
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // One serial clock pulse with data b.
    task automatic send_bit(logic b, string req);
        sdi = b;
        waitc(3);
        sclk = 1'b1;
        waitc(4);
        if (!csld) m_shift = shift_in(m_shift, b);
        chk({req, " sdo"}, {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, m_shift[W-1]});
        sclk = 1'b0;
        waitc(3);
    endtask

    task automatic set_cs(logic v);
        logic was;
        was = csld;
        csld = v;
        waitc(4);
        if (v && !was) m_dac = m_shift;
    endtask

    task automatic send_word(logic [W-1:0] w, int nbits, string req);
        set_cs(1'b0);
        for (int i = nbits - 1; i >= 0; i--) send_bit(w[i % W], req);
        set_cs(1'b1);
        chk({req, " dac_code"}, dac_code, m_dac);
    endtask

    task automatic do_clear();
        @(negedge clk);
        #3 clr_n = 1'b0;
        #1;
        m_shift = '0;
        m_dac = '0;
        chk("R8 async dac_code", dac_code, '0);
        chk("R8 async sdo", {{(W-1){1'b0}}, sdo}, '0);
        waitc(2);
        clr_n = 1'b1;
        waitc(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        waitc(4);
        chk("R1 reset dac_code", dac_code, '0);
        chk("R1 reset sdo", {{(W-1){1'b0}}, sdo}, '0);
        rst_n = 1'b1;
        waitc(4);

        // R2/R5: a plain 12-bit frame, MSB first.
        send_word(12'hA5C, 12, "R2 R5 frame");
        chk("R2 msb-first", dac_code, 12'hA5C);

        // R6: daisy chain, the previous word leaves on sdo MSB first.
        begin
            logic [W-1:0] seen;
            logic [W-1:0] prev;
            prev = m_shift;
            seen = '0;
            set_cs(1'b0);
            for (int i = W - 1; i >= 0; i--) begin
                seen = {seen[W-2:0], sdo};
                send_bit(1'(12'h3C1 >> i), "R6 chain");
            end
            set_cs(1'b1);
            chk("R6 previous word on sdo", seen, prev);
            chk("R5 second word", dac_code, 12'h3C1);
        end

        // R3: clocks with select high are ignored; a bare load recommits.
        for (int i = 0; i < 5; i++) send_bit(1'(i), "R3 ignored clk");
        send_word('0, 0, "R3 hold");
        chk("R3 unchanged word", dac_code, 12'h3C1);

        // R7: short and long frames.
        send_word(12'h0F0, 8, "R7 short");
        send_word(12'h9AB, 14, "R7 long");

        // R10: final clock edge coincides with select rising.
        set_cs(1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b1, "R10 prefix");
        sdi = 1'b0;
        waitc(3);
        sclk = 1'b1;
        csld = 1'b1;
        waitc(4);
        m_dac = m_shift;
        chk("R10 edge ignored", dac_code, m_dac);
        chk("R10 sdo", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, m_shift[W-1]});
        sclk = 1'b0;
        waitc(3);

        // R8/R9: clear, then a load during clear is ignored.
        do_clear();
        chk("R8 after clear", dac_code, '0);
        set_cs(1'b0);
        send_bit(1'b1, "R9 pre");
        @(negedge clk);
        clr_n = 1'b0;
        m_shift = '0;
        m_dac = '0;
        waitc(1);
        csld = 1'b1;
        waitc(4);
        clr_n = 1'b1;
        waitc(4);
        chk("R9 load during clear", dac_code, '0);
        chk("R4 code steady", dac_code, '0);

        // Random frames with occasional clears.
        for (int f = 0; f < 40; f++) begin
            logic [W-1:0] w;
            int n;
            w = W'($urandom);
            n = $urandom_range(10, 14);
            if ($urandom_range(0, 9) == 0) do_clear();
            send_word(w, n, "R5 R7 random");
            waitc(6);
            chk("R4 steady between frames", dac_code, m_dac);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule